// File: doc/BRIEF.md
# Second-Chance Cache Victim Selector

This block picks the way to evict from one cache set of `WAYS` ways. For each way it keeps a valid flag, a reference bit and a `HIST`-bit usage history, and the whole set shares one circular scan pointer. The surrounding cache controller reports three kinds of single-cycle events, each with a way index: a hit, a fill (a new line is installed) and an invalidate. When the controller needs room, it raises a victim request and waits for a one-cycle result pulse that carries the chosen way.

If any way is empty, the lowest-numbered empty way is returned on the next cycle and no history changes. Otherwise the block walks the set from the pointer, one way per cycle. Each visited way pushes its reference bit into the top of its history, and the older history bits move one place down. The reference bit is then cleared and the pointer steps on. A way whose new history is still nonzero survives. The first way whose history becomes zero is the victim. A freshly filled line has a clear reference bit and an empty history, so it gets no extra chance until it is hit. With `HIST` = 1 the block behaves as plain second-chance replacement. Larger values let a referenced line outlive several sweeps.

Top module: `sc_victim_sel`

## Requirements
- R1: After reset, `victim_valid` and `busy` are 0, every way is empty, and the scan pointer is at way 0.
- R2: A victim request accepted while at least one way is empty returns the lowest-numbered empty way, with `victim_valid` high in the cycle after the request edge. Histories and the pointer are left unchanged.
- R3: A fill marks the way valid and clears its reference bit and its history, so an unhit filled way is chosen the first time the scan reaches it, even if it was hit before the fill.
- R4: A hit sets the way's reference bit, so the next scan that reaches the way keeps it.
- R5: A scanned way's new history is its reference bit shifted into the most significant history bit, with the older bits shifted one position toward bit 0. The way is kept while that value is nonzero and chosen when it is zero.
- R6: Every scanned way, kept or chosen, has its reference bit cleared, and the pointer moves to the next way. The pointer wraps from way `WAYS-1` to way 0, so the next scan begins just after the last victim.
- R7: A scan examines exactly one way per clock. If no hit arrives during the scan, `victim_valid` rises at most `HIST*WAYS+1` examinations after the scan starts.
- R8: `victim_valid` is a one-cycle pulse. While `busy` is high (scanning, or a result pulse is showing), requests are ignored and produce no additional result.
- R9: An invalidate marks the way empty, so the next request returns that way if it is the lowest-numbered empty way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_en | input | 1 | Hit strobe |
| hit_way | input | $clog2(WAYS) | Way that hit |
| fill_en | input | 1 | Fill (insert) strobe |
| fill_way | input | $clog2(WAYS) | Way being filled |
| inval_en | input | 1 | Invalidate strobe |
| inval_way | input | $clog2(WAYS) | Way being invalidated |
| vreq | input | 1 | Victim request, taken only while `busy` is low |
| busy | output | 1 | Search in progress or result being shown |
| victim_valid | output | 1 | One-cycle pulse: `victim_way` is valid |
| victim_way | output | $clog2(WAYS) | Chosen way |

## Verification
The assertions check the following on every cycle:
- Each strobe has its local effect on the reference bit: a fill clears it, a hit sets it, and an examination clears it.
- The result pulse lasts exactly one cycle.
- A request that finds an empty way is answered on the next cycle.
- A scan result names the way examined in the cycle before it.
- The scan length stays within the `HIST*WAYS+1` bound, measured by a counter.

Only the bench scenarios can show the behaviour that depends on the sequence of events:
- the exact victim chosen after a given series of hits, fills and invalidates;
- how the history decays over successive sweeps;
- the pointer wrapping around the set;
- a request made while busy producing no extra result.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_SCAN = 1'b1
  } sc_state_e;
endpackage

// File: rtl/sc_way_slot.sv
module sc_way_slot #(
  parameter int HIST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            fill,
  input  logic            inval,
  input  logic            exam,
  output logic            ref_o,
  output logic [HIST-1:0] hist_o,
  output logic            valid_o,
  output logic            keep_o
);
  // usage bit enters at the top, older history moves toward bit 0
  function automatic logic [HIST-1:0] push_use(input logic u, input logic [HIST-1:0] h);
    return (h >> 1) | (HIST'(u) << (HIST - 1));
  endfunction

  logic [HIST-1:0] hist_next;
  assign hist_next = push_use(ref_o, hist_o);
  assign keep_o    = (hist_next != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_o   <= 1'b0;
      hist_o  <= '0;
      valid_o <= 1'b0;
    end else if (inval) begin
      ref_o   <= 1'b0;
      hist_o  <= '0;
      valid_o <= 1'b0;
    end else if (fill) begin
      ref_o   <= 1'b0;
      hist_o  <= '0;
      valid_o <= 1'b1;
    end else begin
      if (exam) hist_o <= hist_next;
      if (hit) ref_o <= 1'b1;
      else if (exam) ref_o <= 1'b0;
    end
  end

  p_fill_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> !ref_o);
  p_hit_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fill && !inval) |=> ref_o);
  p_exam_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exam && !hit && !fill && !inval) |=> !ref_o);
endmodule

// File: rtl/sc_scan_ctl.sv
module sc_scan_ctl
  import sc_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vreq,
  input  logic [WAYS-1:0] valid_vec,
  input  logic [WAYS-1:0] keep_vec,
  output logic [WAYS-1:0] exam_vec,
  output logic            scanning,
  output logic            busy,
  output logic            victim_valid,
  output logic [WW-1:0]   victim_way
);
  function automatic logic [WW-1:0] step_ptr(input logic [WW-1:0] p);
    return (p == WW'(WAYS - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [WW-1:0] lowest_empty(input logic [WAYS-1:0] v);
    logic [WW-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (!v[i]) r = WW'(i);
    return r;
  endfunction

  sc_state_e     state;
  logic [WW-1:0] ptr;
  logic          accept, any_empty, found;

  assign scanning  = (state == SC_SCAN);
  assign busy      = scanning || victim_valid;
  assign accept    = vreq && !busy;
  assign any_empty = !(&valid_vec);
  assign found     = scanning && !keep_vec[ptr];

  always_comb begin
    exam_vec = '0;
    if (scanning) exam_vec[ptr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SC_IDLE;
      ptr          <= '0;
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= 1'b0;
      if (accept) begin
        if (any_empty) begin
          victim_valid <= 1'b1;
          victim_way   <= lowest_empty(valid_vec);
        end else begin
          state <= SC_SCAN;
        end
      end else if (scanning) begin
        ptr <= step_ptr(ptr);
        if (found) begin
          state        <= SC_IDLE;
          victim_valid <= 1'b1;
          victim_way   <= ptr;
        end
      end
    end
  end

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);
  p_fast_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_empty) |=> (victim_valid && !valid_vec[victim_way]));
  p_found_way_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> (victim_valid && victim_way == $past(ptr)));
endmodule

// File: rtl/sc_victim_sel.sv
module sc_victim_sel #(
  parameter int WAYS = 4,
  parameter int HIST = 2,
  localparam int WW = $clog2(WAYS),
  localparam int SCAN_MAX = HIST * WAYS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_en,
  input  logic [WW-1:0] hit_way,
  input  logic          fill_en,
  input  logic [WW-1:0] fill_way,
  input  logic          inval_en,
  input  logic [WW-1:0] inval_way,
  input  logic          vreq,
  output logic          busy,
  output logic          victim_valid,
  output logic [WW-1:0] victim_way
);
  logic [WAYS-1:0] valid_vec, keep_vec, exam_vec, ref_vec;
  logic            scanning;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [HIST-1:0] hist_w;
    sc_way_slot #(.HIST(HIST)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit_en && hit_way == WW'(g)),
      .fill    (fill_en && fill_way == WW'(g)),
      .inval   (inval_en && inval_way == WW'(g)),
      .exam    (exam_vec[g]),
      .ref_o   (ref_vec[g]),
      .hist_o  (hist_w),
      .valid_o (valid_vec[g]),
      .keep_o  (keep_vec[g])
    );
  end

  sc_scan_ctl #(.WAYS(WAYS)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .vreq         (vreq),
    .valid_vec    (valid_vec),
    .keep_vec     (keep_vec),
    .exam_vec     (exam_vec),
    .scanning     (scanning),
    .busy         (busy),
    .victim_valid (victim_valid),
    .victim_way   (victim_way)
  );

  // scan length watch: restarts when a hit could extend the search
  logic [$clog2(SCAN_MAX + 2):0] scan_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !scanning || hit_en) scan_cnt <= '0;
    else scan_cnt <= scan_cnt + 1'b1;
  end

  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_cnt <= SCAN_MAX);
  p_onehot_exam_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exam_vec) && (scanning == (exam_vec != '0)));
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && valid_vec == '0 && ref_vec == '0));
endmodule

// File: tb/test_sc_victim_sel.sv
`timescale 1ns/1ps
module test_sc_victim_sel;
  localparam int WAYS = 4;
  localparam int HIST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_en = 0, fill_en = 0, inval_en = 0, vreq = 0;
  logic [1:0] hit_way = 0, fill_way = 0, inval_way = 0;
  logic busy, victim_valid;
  logic [1:0] victim_way;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sc_victim_sel #(.WAYS(WAYS), .HIST(HIST)) i_sc_victim_sel (
    .clk(clk), .rst_n(rst_n),
    .hit_en(hit_en), .hit_way(hit_way),
    .fill_en(fill_en), .fill_way(fill_way),
    .inval_en(inval_en), .inval_way(inval_way),
    .vreq(vreq), .busy(busy),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_hit(input int w);
    @(negedge clk); hit_en = 1; hit_way = 2'(w);
    @(negedge clk); hit_en = 0;
  endtask
  task automatic do_fill(input int w);
    @(negedge clk); fill_en = 1; fill_way = 2'(w);
    @(negedge clk); fill_en = 0;
  endtask
  task automatic do_inval(input int w);
    @(negedge clk); inval_en = 1; inval_way = 2'(w);
    @(negedge clk); inval_en = 0;
  endtask

  // request a victim; latency counts clocks from request edge to pulse
  task automatic get_victim(input string req, input int exp_way, input int exp_lat);
    int lat;
    @(negedge clk); vreq = 1;
    @(negedge clk); vreq = 0;
    lat = 1;
    while (!victim_valid && lat < 40) begin @(negedge clk); lat++; end
    check({req, " way"}, int'(victim_way), exp_way);
    check({req, " latency"}, lat, exp_lat);
    @(negedge clk);
    check({req, " R8 pulse width"}, int'(victim_valid), 0);
  endtask

  task automatic t_reset;
    check("R1 victim_valid after reset", int'(victim_valid), 0);
    check("R1 busy after reset", int'(busy), 0);
  endtask

  task automatic t_empty_ways;
    get_victim("R1 R2 all empty", 0, 1);
    do_fill(0); do_fill(1);
    get_victim("R2 lowest empty", 2, 1);
    do_fill(2); do_fill(3);
    do_inval(1);
    get_victim("R9 invalidated way", 1, 1);
    do_fill(1);
  endtask

  task automatic t_fresh_fill;
    // pointer at 0 after reset, fresh line has no chance
    get_victim("R3 R1 fresh line from way 0", 0, 2);
  endtask

  task automatic t_hit_kept;
    do_hit(1);
    get_victim("R4 hit way kept", 2, 3);
  endtask

  task automatic t_history;
    do_hit(3); do_hit(0);
    // way1 history 01 still nonzero, way2 empty history
    get_victim("R5 history keeps way1", 2, 5);
  endtask

  task automatic t_wrap_bound;
    do_hit(0); do_hit(1); do_hit(2); do_hit(3);
    get_victim("R7 R6 worst case with wrap", 3, HIST * WAYS + 2);
  endtask

  task automatic t_busy_ignore;
    int pulses;
    pulses = 0;
    @(negedge clk); vreq = 1;
    @(negedge clk); // request still high while scanning
    check("R8 busy during scan", int'(busy), 1);
    @(negedge clk); vreq = 0;
    if (victim_valid) begin
      pulses++;
      check("R6 way after wrap", int'(victim_way), 0);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (victim_valid) pulses++;
    end
    check("R8 ignored request gives one result", pulses, 1);
  endtask

  task automatic t_fill_after_hit;
    do_hit(1);
    do_fill(1);
    get_victim("R3 fill clears earlier hit", 1, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_empty_ways();
    t_fresh_fill();
    t_hit_kept();
    t_history();
    t_wrap_bound();
    t_busy_ignore();
    t_fill_after_hit();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule